// File: doc/BRIEF.md
# Multi-Mode Memory Test Address Sequencer

This block produces the stream of memory addresses that a self-test engine visits. Each address has three fields: column, bank and row. Every field has its own lower and upper bound, so the walk covers a box-shaped region of the address space. A two-bit ordering select picks which fields move fastest. A direction input walks the same region either upward or downward.

A test controller pulses `start_i`. That pulse captures the ordering, the direction and the six bounds. From the next cycle, the sequencer presents an address with `valid_o`. The consumer takes each address by raising `adv_i`. While `adv_i` is low the address is held. The final address of the walk is marked with `last_o`. One cycle after that address is accepted, `done_o` rises and stays high until the next start. Pulsing `start_i` again, with the same settings, reproduces exactly the same sequence. The read-back pass of a test relies on this.

Top module: `tst_addr_seq`

## Requirements
- R1: While reset is applied, and right after it, `valid_o`, `last_o` and `done_o` are all 0.
- R2: In the cycle after a `start_i` pulse, `valid_o` is 1 and `done_o` is 0. The first address is the lower bound of every field when `down_i` = 0, and the upper bound of every field when `down_i` = 1.
- R3: With `mode_i` = 0, the column moves fastest, the row next, and the bank slowest.
- R4: With `mode_i` = 1, the row moves fastest, the column next, and the bank slowest.
- R5: With `mode_i` = 2, the column and the row both step on every accepted address, and each wraps within its own bounds. The bank steps only after an address on which the column and the row are both at their final values. That happens after lcm(column count, row count) addresses.
- R6: With `mode_i` = 3, the column moves fastest, the bank next, and the row slowest.
- R7: With `down_i` = 1, every field counts down from its upper bound. A field that is at its lower bound wraps to its upper bound when it steps. The walk ends on the lower bounds.
- R8: Every presented field value lies within the bounds captured at start.
- R9: While `valid_o` = 1 and `adv_i` = 0, the presented address and `valid_o` stay unchanged.
- R10: `last_o` is 1 exactly on the final address of the walk, and only while `valid_o` = 1.
- R11: One cycle after the final address is accepted, `done_o` is 1 and `valid_o` is 0. `done_o` then stays 1 until the next `start_i`.
- R12: Mode, direction and bounds are captured at `start_i`. Changing them mid-walk has no effect. A new `start_i`, including one in the middle of a walk, restarts the walk from its first address and reproduces the same sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; captures the settings and begins a walk |
| mode_i | input | 2 | Ordering select (0 column-row-bank, 1 row-column-bank, 2 diagonal, 3 column-bank-row) |
| down_i | input | 1 | 1 walks downward, 0 walks upward |
| lo_col_i | input | CW | Column lower bound |
| lo_bank_i | input | BW | Bank lower bound |
| lo_row_i | input | RW | Row lower bound |
| hi_col_i | input | CW | Column upper bound |
| hi_bank_i | input | BW | Bank upper bound |
| hi_row_i | input | RW | Row upper bound |
| adv_i | input | 1 | Consumer accepts the presented address |
| valid_o | output | 1 | An address is presented |
| col_o | output | CW | Current column |
| bank_o | output | BW | Current bank |
| row_o | output | RW | Current row |
| last_o | output | 1 | Presented address is the final one |
| done_o | output | 1 | Walk complete |

## Verification
The bench builds the sequencer with a 3-bit column, a 2-bit bank and a 3-bit row. With these widths a full-range walk has at most 256 addresses. A walk of that length can therefore be checked address by address against a list of expected addresses built from nested loops, for every ordering and both directions. The small field ranges also make wrap-around frequent. In the diagonal ordering they give column and row counts with and without common factors, so the lcm-length inner walk is exercised. Single-point ranges put the first address and the last address on the same cycle.

// File: rtl/tst_addr_seq_pkg.sv
package tst_addr_seq_pkg;
    typedef enum logic [1:0] {
        ORD_COL_ROW_BANK = 2'd0,
        ORD_ROW_COL_BANK = 2'd1,
        ORD_DIAGONAL     = 2'd2,
        ORD_COL_BANK_ROW = 2'd3
    } order_e;
endpackage

// File: rtl/tst_field_step.sv
module tst_field_step #(
    parameter int W = 4
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] hi_i,
    input  logic         down_i,
    output logic [W-1:0] nxt_o,
    output logic         at_fin_o
);
    logic [W-1:0] fin_val;
    logic [W-1:0] wrap_val;

    always_comb begin
        fin_val  = down_i ? lo_i : hi_i;
        wrap_val = down_i ? hi_i : lo_i;
        at_fin_o = (cur_i == fin_val);
        if (at_fin_o) begin
            nxt_o = wrap_val;
        end else if (down_i) begin
            nxt_o = cur_i - W'(1);
        end else begin
            nxt_o = cur_i + W'(1);
        end
    end
endmodule

// File: rtl/tst_order_carry.sv
module tst_order_carry
    import tst_addr_seq_pkg::*;
(
    input  order_e order_i,
    input  logic   c_fin_i,
    input  logic   b_fin_i,
    input  logic   r_fin_i,
    output logic   step_c_o,
    output logic   step_b_o,
    output logic   step_r_o
);
    always_comb begin
        step_c_o = 1'b0;
        step_b_o = 1'b0;
        step_r_o = 1'b0;
        unique case (order_i)
            ORD_COL_ROW_BANK: begin
                step_c_o = 1'b1;
                step_r_o = c_fin_i;
                step_b_o = c_fin_i & r_fin_i;
            end
            ORD_ROW_COL_BANK: begin
                step_r_o = 1'b1;
                step_c_o = r_fin_i;
                step_b_o = c_fin_i & r_fin_i;
            end
            ORD_DIAGONAL: begin
                step_c_o = 1'b1;
                step_r_o = 1'b1;
                step_b_o = c_fin_i & r_fin_i;
            end
            ORD_COL_BANK_ROW: begin
                step_c_o = 1'b1;
                step_b_o = c_fin_i;
                step_r_o = c_fin_i & b_fin_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tst_addr_seq.sv
module tst_addr_seq
    import tst_addr_seq_pkg::*;
#(
    parameter int CW = 10,
    parameter int BW = 3,
    parameter int RW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    mode_i,
    input  logic          down_i,
    input  logic [CW-1:0] lo_col_i,
    input  logic [BW-1:0] lo_bank_i,
    input  logic [RW-1:0] lo_row_i,
    input  logic [CW-1:0] hi_col_i,
    input  logic [BW-1:0] hi_bank_i,
    input  logic [RW-1:0] hi_row_i,
    input  logic          adv_i,
    output logic          valid_o,
    output logic [CW-1:0] col_o,
    output logic [BW-1:0] bank_o,
    output logic [RW-1:0] row_o,
    output logic          last_o,
    output logic          done_o
);
    localparam int AW = CW + BW + RW;

    typedef struct packed {
        order_e        order;
        logic          down;
        logic [CW-1:0] lo_c;
        logic [BW-1:0] lo_b;
        logic [RW-1:0] lo_r;
        logic [CW-1:0] hi_c;
        logic [BW-1:0] hi_b;
        logic [RW-1:0] hi_r;
    } cfg_t;

    typedef struct packed {
        cfg_t          cfg;
        logic [CW-1:0] col;
        logic [BW-1:0] bank;
        logic [RW-1:0] row;
        logic          valid;
        logic          done;
    } state_t;

    state_t st_d, st_q;

    logic [CW-1:0] nxt_c;
    logic [BW-1:0] nxt_b;
    logic [RW-1:0] nxt_r;
    logic          c_fin, b_fin, r_fin;
    logic          step_c, step_b, step_r;
    logic          at_end;
    logic [AW-1:0] addr_flat;

    tst_field_step #(.W(CW)) u_col_step (
        .cur_i(st_q.col), .lo_i(st_q.cfg.lo_c), .hi_i(st_q.cfg.hi_c),
        .down_i(st_q.cfg.down), .nxt_o(nxt_c), .at_fin_o(c_fin)
    );
    tst_field_step #(.W(BW)) u_bank_step (
        .cur_i(st_q.bank), .lo_i(st_q.cfg.lo_b), .hi_i(st_q.cfg.hi_b),
        .down_i(st_q.cfg.down), .nxt_o(nxt_b), .at_fin_o(b_fin)
    );
    tst_field_step #(.W(RW)) u_row_step (
        .cur_i(st_q.row), .lo_i(st_q.cfg.lo_r), .hi_i(st_q.cfg.hi_r),
        .down_i(st_q.cfg.down), .nxt_o(nxt_r), .at_fin_o(r_fin)
    );

    tst_order_carry u_carry (
        .order_i(st_q.cfg.order),
        .c_fin_i(c_fin), .b_fin_i(b_fin), .r_fin_i(r_fin),
        .step_c_o(step_c), .step_b_o(step_b), .step_r_o(step_r)
    );

    assign at_end = c_fin & b_fin & r_fin;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.cfg.order = order_e'(mode_i);
            st_d.cfg.down  = down_i;
            st_d.cfg.lo_c  = lo_col_i;
            st_d.cfg.lo_b  = lo_bank_i;
            st_d.cfg.lo_r  = lo_row_i;
            st_d.cfg.hi_c  = hi_col_i;
            st_d.cfg.hi_b  = hi_bank_i;
            st_d.cfg.hi_r  = hi_row_i;
            st_d.col       = down_i ? hi_col_i  : lo_col_i;
            st_d.bank      = down_i ? hi_bank_i : lo_bank_i;
            st_d.row       = down_i ? hi_row_i  : lo_row_i;
            st_d.valid     = 1'b1;
            st_d.done      = 1'b0;
        end else if (st_q.valid && adv_i) begin
            if (at_end) begin
                st_d.valid = 1'b0;
                st_d.done  = 1'b1;
            end else begin
                if (step_c) st_d.col  = nxt_c;
                if (step_b) st_d.bank = nxt_b;
                if (step_r) st_d.row  = nxt_r;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o   = st_q.valid;
    assign col_o     = st_q.col;
    assign bank_o    = st_q.bank;
    assign row_o     = st_q.row;
    assign last_o    = st_q.valid & at_end;
    assign done_o    = st_q.done;
    assign addr_flat = {st_q.row, st_q.bank, st_q.col};

    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o && !done_o &&
            col_o  == ($past(down_i) ? $past(hi_col_i)  : $past(lo_col_i)) &&
            bank_o == ($past(down_i) ? $past(hi_bank_i) : $past(lo_bank_i)) &&
            row_o  == ($past(down_i) ? $past(hi_row_i)  : $past(lo_row_i))); // R2

    AST_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> col_o >= st_q.cfg.lo_c && col_o <= st_q.cfg.hi_c &&
                    bank_o >= st_q.cfg.lo_b && bank_o <= st_q.cfg.hi_b &&
                    row_o >= st_q.cfg.lo_r && row_o <= st_q.cfg.hi_r); // R8

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !adv_i && !start_i |=> valid_o && $stable(addr_flat)); // R9

    AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o); // R10

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && adv_i && last_o && !start_i |=> done_o && !valid_o); // R11

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o); // R11

    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && valid_o)); // R11
endmodule

// File: tb/tst_addr_seq_bench.sv
module tst_addr_seq_bench;
    localparam int CW = 3;
    localparam int BW = 2;
    localparam int RW = 3;
    localparam int MAXN = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [1:0] mode_i = '0;
    logic down_i = 1'b0;
    logic [CW-1:0] lo_col_i = '0, hi_col_i = '0;
    logic [BW-1:0] lo_bank_i = '0, hi_bank_i = '0;
    logic [RW-1:0] lo_row_i = '0, hi_row_i = '0;
    logic adv_i = 1'b0;
    logic valid_o, last_o, done_o;
    logic [CW-1:0] col_o;
    logic [BW-1:0] bank_o;
    logic [RW-1:0] row_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int exp_c [MAXN];
    int exp_b [MAXN];
    int exp_r [MAXN];
    int exp_n;

    int cfg_mode, cfg_down, lc, hc, lb, hb, lr, hr;

    always #4 clk = ~clk;

    tst_addr_seq #(.CW(CW), .BW(BW), .RW(RW)) u_tst_addr_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .down_i(down_i), .lo_col_i(lo_col_i), .lo_bank_i(lo_bank_i),
        .lo_row_i(lo_row_i), .hi_col_i(hi_col_i), .hi_bank_i(hi_bank_i),
        .hi_row_i(hi_row_i), .adv_i(adv_i), .valid_o(valid_o),
        .col_o(col_o), .bank_o(bank_o), .row_o(row_o),
        .last_o(last_o), .done_o(done_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired: actual %0d cycles, expected under 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int fv(input int lo, input int n, input int i, input int dn);
        return (dn != 0) ? lo + n - 1 - i : lo + i;
    endfunction

    function automatic int gcd(input int a, input int b);
        int x = a;
        int y = b;
        while (y != 0) begin
            int t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic void push(input int c, input int b, input int r);
        exp_c[exp_n] = c;
        exp_b[exp_n] = b;
        exp_r[exp_n] = r;
        exp_n = exp_n + 1;
    endfunction

    // Expected list built from nested loops, one shape per ordering.
    function automatic void build();
        int nc = hc - lc + 1;
        int nb = hb - lb + 1;
        int nr = hr - lr + 1;
        int span = nc / gcd(nc, nr) * nr;
        exp_n = 0;
        case (cfg_mode)
            0: for (int b = 0; b < nb; b++) for (int r = 0; r < nr; r++) for (int c = 0; c < nc; c++)
                push(fv(lc, nc, c, cfg_down), fv(lb, nb, b, cfg_down), fv(lr, nr, r, cfg_down));
            1: for (int b = 0; b < nb; b++) for (int c = 0; c < nc; c++) for (int r = 0; r < nr; r++)
                push(fv(lc, nc, c, cfg_down), fv(lb, nb, b, cfg_down), fv(lr, nr, r, cfg_down));
            2: for (int b = 0; b < nb; b++) for (int k = 0; k < span; k++)
                push(fv(lc, nc, k % nc, cfg_down), fv(lb, nb, b, cfg_down), fv(lr, nr, k % nr, cfg_down));
            default: for (int r = 0; r < nr; r++) for (int b = 0; b < nb; b++) for (int c = 0; c < nc; c++)
                push(fv(lc, nc, c, cfg_down), fv(lb, nb, b, cfg_down), fv(lr, nr, r, cfg_down));
        endcase
    endfunction

    function automatic string mode_req();
        if (cfg_down != 0) return "R7";
        case (cfg_mode)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic drive_cfg();
        mode_i    = 2'(cfg_mode);
        down_i    = (cfg_down != 0);
        lo_col_i  = CW'(lc);
        hi_col_i  = CW'(hc);
        lo_bank_i = BW'(lb);
        hi_bank_i = BW'(hb);
        lo_row_i  = RW'(lr);
        hi_row_i  = RW'(hr);
    endtask

    // Stop after abort_at accepted addresses (negative runs the whole walk).
    task automatic run_walk(input int stall_pct, input int abort_at);
        int idx = 0;
        string rq = mode_req();
        build();
        @(negedge clk);
        drive_cfg();
        start_i = 1'b1;
        adv_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        // R12: scramble the settings after capture.
        mode_i = 2'(cfg_mode + 1);
        down_i = ~down_i;
        lo_col_i = '1; hi_col_i = '0; lo_bank_i = '1; hi_bank_i = '0;
        lo_row_i = '1; hi_row_i = '0;
        chk(valid_o == 1'b1 && done_o == 1'b0, "R2", "valid after start", int'(valid_o), 1);
        while (idx < exp_n) begin
            bit acc;
            chk(valid_o == 1'b1, rq, "valid during walk", int'(valid_o), 1);
            chk(int'(col_o) == exp_c[idx], rq, "column", int'(col_o), exp_c[idx]);
            chk(int'(bank_o) == exp_b[idx], rq, "bank", int'(bank_o), exp_b[idx]);
            chk(int'(row_o) == exp_r[idx], rq, "row", int'(row_o), exp_r[idx]);
            chk(int'(col_o) >= lc && int'(col_o) <= hc && int'(row_o) >= lr && int'(row_o) <= hr
                && int'(bank_o) >= lb && int'(bank_o) <= hb, "R8", "bounds", int'(col_o), lc);
            chk(last_o == (idx == exp_n - 1), "R10", "last flag", int'(last_o), int'(idx == exp_n - 1));
            if (idx == abort_at) return;
            acc = ($urandom % 100) >= stall_pct;
            adv_i = acc;
            @(negedge clk);
            if (acc) idx++;
        end
        adv_i = 1'b0;
        chk(done_o == 1'b1 && valid_o == 1'b0, "R11", "done after last", int'(done_o), 1);
        @(negedge clk);
        @(negedge clk);
        chk(done_o == 1'b1 && valid_o == 1'b0, "R11", "done held", int'(done_o), 1);
    endtask

    task automatic rand_bounds();
        int a, b;
        a = $urandom % 8; b = $urandom % 8;
        lc = (a < b) ? a : b; hc = (a < b) ? b : a;
        a = $urandom % 4; b = $urandom % 4;
        lb = (a < b) ? a : b; hb = (a < b) ? b : a;
        a = $urandom % 8; b = $urandom % 8;
        lr = (a < b) ? a : b; hr = (a < b) ? b : a;
    endtask

    initial begin
        void'($urandom(32'd1357));
        #1;
        chk(valid_o == 1'b0 && last_o == 1'b0 && done_o == 1'b0, "R1", "reset outputs", int'(valid_o), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid_o == 1'b0 && last_o == 1'b0 && done_o == 1'b0, "R1", "after reset", int'(done_o), 0);

        // Full range, every ordering, both directions.
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 2; d++) begin
                cfg_mode = m; cfg_down = d;
                lc = 0; hc = 7; lb = 0; hb = 3; lr = 0; hr = 7;
                run_walk(20, -1);
            end
        end

        // Diagonal with coprime and non-coprime counts.
        cfg_mode = 2; cfg_down = 0;
        lc = 1; hc = 3; lb = 1; hb = 2; lr = 2; hr = 3;
        run_walk(0, -1);
        cfg_down = 1;
        lc = 0; hc = 5; lb = 0; hb = 1; lr = 4; hr = 7;
        run_walk(30, -1);

        // Single-point range: first address is also last.
        cfg_mode = 3; cfg_down = 1;
        lc = 5; hc = 5; lb = 2; hb = 2; lr = 6; hr = 6;
        run_walk(0, -1);

        // R12: restart mid-walk, then the full walk must match.
        cfg_mode = 1; cfg_down = 0;
        lc = 2; hc = 6; lb = 1; hb = 3; lr = 1; hr = 4;
        run_walk(0, 5);
        run_walk(10, -1);

        // Constrained random trials.
        for (int t = 0; t < 40; t++) begin
            cfg_mode = int'($urandom % 4);
            cfg_down = int'($urandom % 2);
            rand_bounds();
            run_walk(int'($urandom % 60), -1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule